// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is a small word machine with one accumulator. Fixed, hardwired logic steps it through four phases: instruction read, pointer resolution, execution and interrupt entry. Each clock performs one group of register transfers. The block holds a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. It drives a single-port memory through an address bus, a write-data bus, a read-data bus and separate read and write strobes.

Instruction words are 16 bits wide. The top three bits carry the operation and bit 12 is the indirection flag. The low 12 bits hold an operand address. The block executes three operations: add-to-accumulator, increment-memory-and-skip-if-zero, and call, which stores a return address and continues at the next word. There is also a stop operation. An interrupt request is taken between instructions. Taking it writes the current program counter to a fixed save location and jumps to a fixed service address. The block answers with a one-cycle acknowledge and then accepts no further requests until reset.

Top module: `useq_top`

## Requirements
- R1: Synchronous reset sets the program counter to 0x010, clears the accumulator, selects phase code 00 and enables interrupts. During reset and in the first cycle after it, neither memory strobe is asserted.
- R2: Instruction read takes three cycles. In the first cycle no strobe is asserted. In the second, the read strobe is high, the address is the old program counter, and the program counter becomes that value plus one. The third cycle moves the buffered word into the instruction register.
- R3: The phase output uses 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. After fetch the phase is 01 when bit 12 of the fetched word is set, otherwise 10. After indirect the phase is always 10. Operation codes in bits 15:13 are 000 add, 001 increment-skip, 010 call and 111 stop.
- R4: The indirect phase reads the word at the operand address. It replaces the operand address with the low 12 bits of that word, and the operation then runs on that address.
- R5: Add runs in three execute cycles and leaves the accumulator equal to its old value plus the operand word, modulo 2^16.
- R6: Increment-skip runs in four execute cycles. The final cycle writes the operand word plus one back to the operand address. When the written value is zero, the program counter also advances by one in that cycle, so the next instruction is skipped.
- R7: Call stores the zero-extended address of the following instruction at the operand address X and continues execution at X+1.
- R8: When an instruction's execute phase ends with the request high and interrupts enabled, phase 11 follows. The acknowledge is high for exactly its first cycle, the program counter is stored at address 0x000, execution resumes at 0x001, and interrupts become disabled. Requests made after that are ignored.
- R9: Operation code 111, and any code not listed in R3, stops the machine. The stopped flag rises, the program counter holds, and no memory strobe is asserted again until reset.
- R10: The read and write strobes are never high together, and the write strobe is high only in the execute or interrupt phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the read strobe |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe; the write commits at the rising edge |
| irq_ack | output | 1 | One-cycle acknowledge on interrupt entry |
| phase | output | 2 | Current phase code |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| halted | output | 1 | High once a stop has executed |

## Verification
The assertions assume that read data is settled in the cycle the read strobe is high, and that memory keeps a written word until it is written again. The bench meets both with a behavioural memory that reads combinationally and writes on the clock edge. The assertions place no limit on the request input, which may change in any cycle. The bench holds it at a level for a whole program to exercise the enable latch-off. Every program ends with a stop word, so each run finishes in a known state that the bench can inspect.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  localparam logic [2:0] OPC_ADD  = 3'b000;
  localparam logic [2:0] OPC_ISZ  = 3'b001;
  localparam logic [2:0] OPC_BSA  = 3'b010;
  localparam logic [2:0] OPC_HALT = 3'b111;

  // one bit per register transfer the sequencer may request in a step
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic mbr_inc;
    logic ir_from_mbr;
    logic ir_addr_from_mbr;
    logic pc_inc;
    logic pc_from_ir;
    logic pc_from_vec;
    logic pc_skip_zero;
    logic acc_add;
    logic mem_rd;
    logic mem_wr;
  } uop_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  logic [2:0] ir_op,
  input  logic       mbr_ind,
  output uop_t       uop,
  output phase_e     phase_q,
  output logic       halted_q,
  output logic       irq_ack
);

  localparam int STW = 2;

  logic [STW-1:0] step_q;
  logic           ien_q;
  logic           last_step;
  logic           halt_now;
  phase_e         phase_nxt;
  logic           take_irq;

  assign take_irq = irq && ien_q;

  always_comb begin
    uop       = '0;
    last_step = 1'b0;
    halt_now  = 1'b0;
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_FETCH: begin
        unique case (step_q)
          2'd0: uop.mar_from_pc = 1'b1;
          2'd1: begin
            uop.mem_rd       = 1'b1;
            uop.mbr_from_mem = 1'b1;
            uop.pc_inc       = 1'b1;
          end
          default: begin
            uop.ir_from_mbr = 1'b1;
            last_step       = 1'b1;
            phase_nxt       = mbr_ind ? PH_INDIR : PH_EXEC;
          end
        endcase
      end
      PH_INDIR: begin
        unique case (step_q)
          2'd0: uop.mar_from_ir = 1'b1;
          2'd1: begin
            uop.mem_rd       = 1'b1;
            uop.mbr_from_mem = 1'b1;
          end
          default: begin
            uop.ir_addr_from_mbr = 1'b1;
            last_step            = 1'b1;
            phase_nxt            = PH_EXEC;
          end
        endcase
      end
      PH_EXEC: begin
        if (!halted_q) begin
          unique case (ir_op)
            OPC_ADD: begin
              unique case (step_q)
                2'd0: uop.mar_from_ir = 1'b1;
                2'd1: begin
                  uop.mem_rd       = 1'b1;
                  uop.mbr_from_mem = 1'b1;
                end
                default: begin
                  uop.acc_add = 1'b1;
                  last_step   = 1'b1;
                end
              endcase
            end
            OPC_ISZ: begin
              unique case (step_q)
                2'd0: uop.mar_from_ir = 1'b1;
                2'd1: begin
                  uop.mem_rd       = 1'b1;
                  uop.mbr_from_mem = 1'b1;
                end
                2'd2: uop.mbr_inc = 1'b1;
                default: begin
                  uop.mem_wr       = 1'b1;
                  uop.pc_skip_zero = 1'b1;
                  last_step        = 1'b1;
                end
              endcase
            end
            OPC_BSA: begin
              unique case (step_q)
                2'd0: begin
                  uop.mar_from_ir = 1'b1;
                  uop.mbr_from_pc = 1'b1;
                end
                2'd1: begin
                  uop.pc_from_ir = 1'b1;
                  uop.mem_wr     = 1'b1;
                end
                default: begin
                  uop.pc_inc = 1'b1;
                  last_step  = 1'b1;
                end
              endcase
            end
            default: halt_now = 1'b1;
          endcase
          if (last_step) phase_nxt = take_irq ? PH_INTR : PH_FETCH;
        end
      end
      default: begin
        unique case (step_q)
          2'd0: uop.mbr_from_pc = 1'b1;
          2'd1: begin
            uop.mar_from_save = 1'b1;
            uop.pc_from_vec   = 1'b1;
          end
          default: begin
            uop.mem_wr = 1'b1;
            last_step  = 1'b1;
            phase_nxt  = PH_FETCH;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_FETCH;
      step_q   <= '0;
      ien_q    <= 1'b1;
      halted_q <= 1'b0;
    end else if (halt_now) begin
      halted_q <= 1'b1;
    end else if (last_step) begin
      phase_q <= phase_nxt;
      step_q  <= '0;
      if (phase_nxt == PH_INTR) ien_q <= 1'b0;
    end else if (!halted_q) begin
      step_q <= step_q + 1'b1;
    end
  end

  assign irq_ack = (phase_q == PH_INTR) && (step_q == '0);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(uop.mem_rd && uop.mem_wr));

  // R3
  after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FETCH && last_step) |=> (phase_q == PH_INDIR || phase_q == PH_EXEC));

  // R3
  after_indir_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INDIR && last_step) |=> (phase_q == PH_EXEC));

  // R8
  ack_once_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (!ien_q && !irq_ack));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && uop == '0));

endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC  = 12'h010,
  parameter logic [AW-1:0] SAVE_ADDR = 12'h000,
  parameter logic [AW-1:0] VEC_ADDR  = 12'h001
)(
  input  logic          clk,
  input  logic          rst,
  input  uop_t          uop,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mbr_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] acc_q,
  output logic [2:0]    ir_op,
  output logic          mbr_ind
);

  localparam int PADW = DW - AW;

  logic [DW-1:0] ir_q;
  logic          mbr_zero;
  logic          skip_now;

  function automatic logic [DW-1:0] word_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] word_inc(input logic [DW-1:0] a);
    return a + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  assign mbr_zero = (mbr_q == '0);
  assign skip_now = uop.pc_skip_zero && mbr_zero;
  assign ir_op    = ir_q[DW-1 -: 3];
  assign mbr_ind  = mbr_q[AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (uop.mar_from_pc)        mar_q <= pc_q;
      else if (uop.mar_from_ir)   mar_q <= ir_q[AW-1:0];
      else if (uop.mar_from_save) mar_q <= SAVE_ADDR;

      if (uop.mbr_from_mem)      mbr_q <= mem_rdata;
      else if (uop.mbr_from_pc)  mbr_q <= {{PADW{1'b0}}, pc_q};
      else if (uop.mbr_inc)      mbr_q <= word_inc(mbr_q);

      if (uop.ir_from_mbr)           ir_q <= mbr_q;
      else if (uop.ir_addr_from_mbr) ir_q <= {ir_q[DW-1:AW], mbr_q[AW-1:0]};

      if (uop.pc_from_vec)                 pc_q <= VEC_ADDR;
      else if (uop.pc_from_ir)             pc_q <= ir_q[AW-1:0];
      else if (uop.pc_inc || skip_now)     pc_q <= addr_inc(pc_q);

      if (uop.acc_add) acc_q <= word_add(acc_q, mbr_q);
    end
  end

  // R6
  isz_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (uop.pc_skip_zero && mbr_zero) |=> (pc_q == addr_inc($past(pc_q))));

  // R6
  isz_noskip_chk: assert property (@(posedge clk) disable iff (rst)
    (uop.pc_skip_zero && !mbr_zero) |=> $stable(pc_q));

  // R2
  fetch_read_chk: assert property (@(posedge clk) disable iff (rst)
    uop.mar_from_pc |=> (mar_q == pc_q));

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC  = 12'h010,
  parameter logic [AW-1:0] SAVE_ADDR = 12'h000,
  parameter logic [AW-1:0] VEC_ADDR  = 12'h001
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          irq_ack,
  output logic [1:0]    phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          halted
);

  uop_t       uop;
  phase_e     phase_q;
  logic [2:0] ir_op;
  logic       mbr_ind;

  useq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .ir_op    (ir_op),
    .mbr_ind  (mbr_ind),
    .uop      (uop),
    .phase_q  (phase_q),
    .halted_q (halted),
    .irq_ack  (irq_ack)
  );

  useq_dpath #(
    .AW(AW), .DW(DW), .RESET_PC(RESET_PC), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .mar_q     (mem_addr),
    .mbr_q     (mem_wdata),
    .pc_q      (pc),
    .acc_q     (acc),
    .ir_op     (ir_op),
    .mbr_ind   (mbr_ind)
  );

  assign mem_rd = uop.mem_rd;
  assign mem_wr = uop.mem_wr;
  assign phase  = phase_q;

  // R10
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (phase == 2'b10 || phase == 2'b11));

  // R9
  halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R8
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> ##1 (pc == VEC_ADDR));

endmodule

// File: tb/test_useq_top.sv
module test_useq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr, irq_ack, halted;
  logic [1:0]  phase;
  logic [11:0] pc;
  logic [15:0] acc;

  logic [15:0] mem [0:255];

  int total = 0;
  int bad   = 0;
  int acks, viol, cyc;
  bit seen_ind;

  always #4 clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .irq_ack(irq_ack), .phase(phase), .pc(pc), .acc(acc), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_prog(input int limit);
    acks = 0; viol = 0; cyc = 0; seen_ind = 0;
    while (!halted && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (mem_rd && mem_wr) viol++;
      if (mem_wr && phase != 2'b10 && phase != 2'b11) viol++;
      if (irq_ack) acks++;
      if (phase == 2'b01) seen_ind = 1;
    end
    chk("run ends by stop", {31'd0, halted}, 32'd1);
    chk("R10 strobe rules", viol, 0);
  endtask

  task automatic t_reset_fetch();
    clear_mem();
    mem[8'h10] = 16'hE000;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 strobes in reset", {mem_rd, mem_wr}, 0);
    do_reset();
    chk("R1 pc", pc, 12'h010);
    chk("R1 acc", acc, 0);
    chk("R1 phase", phase, 2'b00);
    chk("R1 strobes first cycle", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    chk("R2 read strobe step2", mem_rd, 1);
    chk("R2 address is pc", mem_addr, 12'h010);
    @(negedge clk);
    chk("R2 pc incremented", pc, 12'h011);
    chk("R2 no read step3", mem_rd, 0);
    @(negedge clk);
    chk("R3 exec after direct fetch", phase, 2'b10);
    run_prog(50);
  endtask

  task automatic t_add();
    clear_mem();
    mem[8'h10] = 16'h0080;
    mem[8'h11] = 16'h0081;
    mem[8'h12] = 16'hE000;
    mem[8'h80] = 16'h1234;
    mem[8'h81] = 16'hF000;
    do_reset();
    run_prog(100);
    chk("R5 add wraps", acc, 16'h0234);
    chk("R5 pc after stop", pc, 12'h013);
    chk("R8 no ack without request", acks, 0);
  endtask

  task automatic t_indirect();
    clear_mem();
    mem[8'h10] = 16'h1090;
    mem[8'h11] = 16'hE000;
    mem[8'h90] = 16'hA085;
    mem[8'h85] = 16'h0007;
    mem[8'h90 - 8'h05] = 16'h0007;
    do_reset();
    run_prog(100);
    chk("R4 indirect operand", acc, 16'h0007);
    chk("R3 indirect phase seen", {31'd0, seen_ind}, 1);
  endtask

  task automatic t_isz();
    clear_mem();
    mem[8'h10] = 16'h2080;
    mem[8'h11] = 16'h2080;
    mem[8'h12] = 16'h0081;
    mem[8'h13] = 16'hE000;
    mem[8'h80] = 16'hFFFE;
    mem[8'h81] = 16'h0005;
    do_reset();
    run_prog(200);
    chk("R6 written back", mem[8'h80], 16'h0000);
    chk("R6 skip on zero only", acc, 16'h0000);
    chk("R6 pc after skip", pc, 12'h014);
  endtask

  task automatic t_bsa();
    clear_mem();
    mem[8'h10] = 16'h4040;
    mem[8'h41] = 16'h0081;
    mem[8'h42] = 16'hE000;
    mem[8'h81] = 16'h0003;
    do_reset();
    run_prog(100);
    chk("R7 return addr saved", mem[8'h40], 16'h0011);
    chk("R7 continues at X+1", acc, 16'h0003);
    chk("R7 pc after stop", pc, 12'h043);
  endtask

  task automatic t_irq();
    clear_mem();
    mem[8'h01] = 16'h0082;
    mem[8'h02] = 16'hE000;
    mem[8'h10] = 16'h0081;
    mem[8'h11] = 16'hE000;
    mem[8'h81] = 16'h0001;
    mem[8'h82] = 16'h0010;
    irq = 1'b1;
    do_reset();
    run_prog(200);
    irq = 1'b0;
    chk("R8 pc saved at 0", mem[8'h00], 16'h0011);
    chk("R8 service routine ran", acc, 16'h0011);
    chk("R8 one ack only", acks, 1);
    chk("R8 pc after stop", pc, 12'h003);
  endtask

  task automatic t_halt();
    int strobes;
    clear_mem();
    mem[8'h10] = 16'h6000;
    mem[8'h11] = 16'h0081;
    mem[8'h81] = 16'h0009;
    do_reset();
    run_prog(50);
    strobes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) strobes++;
    end
    chk("R9 undefined code stops", pc, 12'h011);
    chk("R9 no strobes after stop", strobes, 0);
    chk("R9 stays stopped", {31'd0, halted}, 1);
    chk("R9 acc untouched", acc, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_fetch();
    t_add();
    t_indirect();
    t_isz();
    t_bsa();
    t_irq();
    t_halt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule